// File: doc/BRIEF.md
# Function-select GPIO bank

A bank of general-purpose pins behind a small 32-bit register bus. Every pin owns a 4-bit function code held in a control word. The code decides whether the pin is a plain input, a plain output driven from the bank's data word, or a pin handed to one of several alternate peripheral sources.

The pad buffers sit outside the block. For each pin the block provides an output value and an output enable, and it takes the raw pad level as an input. Alternate peripherals present their per-pin output value and enable on two wide input vectors, grouped by source.

A layout parameter selects one of two bank shapes:
- **Compact layout:** at most 8 pins, with one control word followed by the data word.
- **Wide layout:** at most 16 pins, with codes for pins 8 and up in a second control word and the data word one slot further on.

Software reads of the data word return the latched bit for output pins and the synchronized pad level for every other pin.

Top module: `gpio_fsel_bank`

## Requirements
- R1: While reset is asserted and after it is released, every function code is 0, every data bit is 0, and `pin_oe` and `pin_out` are all 0.
- R2: Pin n below 8 takes its code from bits [4n+3:4n] of the word at byte offset 0x00. A read of 0x00 returns the stored codes and returns 0 in bits of pins the bank does not have.
- R3: In the wide layout (`WIDE`=1), pin n≥8 takes its code from bits [4(n-8)+3:4(n-8)] of the word at 0x04, and the data word sits at 0x08. Bits beyond the bank's pins read as 0.
- R4: Code 4'b0000 makes a pin an input: `pin_oe` is 0 and `pin_out` is 0.
- R5: Code 4'b0001 makes a pin an output: `pin_oe` is 1 and `pin_out` equals data bit n.
- R6: A code c from 2 to 15 selects source k=c-2. If k < `NALT`, `pin_out[n]`=`alt_out[k*NPINS+n]` and `pin_oe[n]`=`alt_oe[k*NPINS+n]`. If k ≥ `NALT`, the pin behaves as an input (both outputs 0).
- R7: A read of the data word returns, in bit n, data bit n for a pin with code 1 and the synchronized pad level for any other code. Bits at and above `NPINS` read as 0.
- R8: A change on `pin_in` appears in a data-word read after exactly two rising clock edges, and not after one.
- R9: A read of any offset other than the mapped words returns 0. A write to such an offset changes no code and no data bit.
- R10: A write to the data word stores every pin's bit whatever the pin's code. A pin later switched to output drives the stored bit.
- R11: In the compact layout (`WIDE`=0), the data word sits at 0x04, and 0x08 is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Byte offset of the access |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pin_in | input | NPINS | Raw pad levels |
| pin_out | output | NPINS | Per-pin output value to the pad |
| pin_oe | output | NPINS | Per-pin output enable to the pad |
| alt_out | input | NALT*NPINS | Alternate-source output values, source k at bits [k*NPINS +: NPINS] |
| alt_oe | input | NALT*NPINS | Alternate-source output enables, same grouping |

## Verification
The assertions check the following on every cycle:
- reset leaves no pin driven;
- a code-0 pin never drives;
- a code without a connected source never enables a driver;
- a data write immediately reaches an output pin;
- writes to unmapped offsets leave all state unchanged;
- input reads lag the pad by exactly two edges.

Only the bench's scenarios can show the following:
- the nibble placement across the two control words;
- the mapping from an alternate code to its source vector;
- the mixed read-back of latched and sampled bits;
- data retained while a pin is an input;
- the compact layout's address map.

// File: rtl/gpio_fsel_bank.sv
module gpio_fsel_bank #(
  parameter int NPINS = 12,
  parameter int WIDE  = 1,
  parameter int NALT  = 3,
  parameter int AW    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         addr,
  input  logic                  wr_en,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  input  logic [NPINS-1:0]      pin_in,
  output logic [NPINS-1:0]      pin_out,
  output logic [NPINS-1:0]      pin_oe,
  input  logic [NALT*NPINS-1:0] alt_out,
  input  logic [NALT*NPINS-1:0] alt_oe
);
  localparam int LO_N    = (NPINS > 8) ? 8 : NPINS;
  localparam int DAT_OFF = (WIDE != 0) ? 8 : 4;

  logic sel_c0, sel_c1, sel_d;
  logic [4*NPINS-1:0] cfg_q;
  logic [NPINS-1:0]   dat_q, sync1_q, sync2_q, rd_dat;

  assign sel_c0 = (addr == AW'(0));
  assign sel_c1 = (WIDE != 0) && (addr == AW'(4));
  assign sel_d  = (addr == AW'(DAT_OFF));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cfg_q <= '0;
    else if (wr_en)
      for (int n = 0; n < NPINS; n++)
        if ((n < 8 && sel_c0) || (n >= 8 && sel_c1))
          cfg_q[4*n +: 4] <= wdata[4*(n%8) +: 4];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dat_q <= '0;
    else if (wr_en && sel_d) dat_q <= wdata[NPINS-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic [3:0] code;
    logic [4:0] src;
    logic       drv_o, drv_e;
    assign code = cfg_q[4*n +: 4];
    assign src  = {1'b0, code} - 5'd2;
    always_comb begin
      drv_o = 1'b0;
      drv_e = 1'b0;
      if (code == 4'd1) begin
        drv_o = dat_q[n];
        drv_e = 1'b1;
      end else if (code >= 4'd2 && int'(src) < NALT) begin
        drv_o = alt_out[int'(src)*NPINS + n];
        drv_e = alt_oe[int'(src)*NPINS + n];
      end
    end
    assign pin_out[n] = drv_o;
    assign pin_oe[n]  = drv_e;
    assign rd_dat[n]  = (code == 4'd1) ? dat_q[n] : sync2_q[n];
  end

  always_comb begin
    rdata = '0;
    if (sel_c0)
      for (int n = 0; n < LO_N; n++) rdata[4*n +: 4] = cfg_q[4*n +: 4];
    else if (sel_c1)
      for (int n = 8; n < NPINS; n++) rdata[4*(n-8) +: 4] = cfg_q[4*n +: 4];
    else if (sel_d)
      rdata[NPINS-1:0] = rd_dat;
  end
endmodule

// File: rtl/gpio_fsel_bank_chk.sv
module gpio_fsel_bank_chk #(
  parameter int NPINS = 12,
  parameter int WIDE  = 1,
  parameter int NALT  = 3,
  parameter int AW    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [AW-1:0]        addr,
  input logic                 wr_en,
  input logic [31:0]          wdata,
  input logic [31:0]          rdata,
  input logic [NPINS-1:0]     pin_in,
  input logic [NPINS-1:0]     pin_out,
  input logic [NPINS-1:0]     pin_oe,
  input logic [4*NPINS-1:0]   cfg_q,
  input logic [NPINS-1:0]     dat_q
);
  localparam int LO_N    = (NPINS > 8) ? 8 : NPINS;
  localparam int DAT_OFF = (WIDE != 0) ? 8 : 4;

  logic mapped;
  logic [1:0] up_cnt;
  assign mapped = (addr == AW'(0)) || (WIDE != 0 && addr == AW'(4)) || (addr == AW'(DAT_OFF));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |-> (pin_oe == '0 && pin_out == '0));

  a_r2_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(0)) |=> cfg_q[4*LO_N-1:0] == $past(wdata[4*LO_N-1:0]));

  a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mapped) |=> ($stable(cfg_q) && $stable(dat_q)));

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    a_r4_input_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[4*n +: 4] == 4'd0) |-> (!pin_oe[n] && !pin_out[n]));

    a_r6_no_source: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[4*n +: 4] >= 4'd2 && int'(cfg_q[4*n +: 4]) - 2 >= NALT) |-> !pin_oe[n]);

    a_r5_data_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'(DAT_OFF) && cfg_q[4*n +: 4] == 4'd1) |=> (pin_oe[n] && pin_out[n] == $past(wdata[n])));

    a_r8_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
      (up_cnt == 2'd3 && addr == AW'(DAT_OFF) && cfg_q[4*n +: 4] != 4'd1) |-> rdata[n] == $past(pin_in[n], 2));
  end
endmodule

bind gpio_fsel_bank gpio_fsel_bank_chk #(.NPINS(NPINS), .WIDE(WIDE), .NALT(NALT), .AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
  .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .cfg_q(cfg_q), .dat_q(dat_q)
);

// File: tb/gpio_fsel_bank_test.sv
module gpio_fsel_bank_test;
  localparam int NPINS = 12;
  localparam int NALT  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_c;
  logic [NPINS-1:0] pin_in = '0;
  logic [NPINS-1:0] pin_out, pin_oe;
  logic [7:0] pin_out_c, pin_oe_c;
  logic [NALT*NPINS-1:0] alt_out = 36'h9_3C5_A6F_0;
  logic [NALT*NPINS-1:0] alt_oe  = 36'h5_F0A_C3E_7;
  logic [NALT*8-1:0] alt_c = '0;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_fsel_bank #(.NPINS(NPINS), .WIDE(1), .NALT(NALT), .AW(8)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .alt_out(alt_out), .alt_oe(alt_oe));

  gpio_fsel_bank #(.NPINS(8), .WIDE(0), .NALT(NALT), .AW(8)) uut_c (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata_c),
    .pin_in(pin_in[7:0]), .pin_out(pin_out_c), .pin_oe(pin_oe_c), .alt_out(alt_c), .alt_oe(alt_c));

  localparam int NV = 13;
  localparam logic [72:0] VEC [NV] = '{
    {8'h00, 1'b1, 32'h76543210, 32'h76543210},
    {8'h04, 1'b1, 32'hFFFFA1F1, 32'h0000A1F1},
    {8'h08, 1'b1, 32'hFFFFFFFF, 32'h00000502},
    {8'h0C, 1'b1, 32'hFFFFFFFF, 32'h00000000},
    {8'h00, 1'b0, 32'h00000000, 32'h76543210},
    {8'h04, 1'b0, 32'h00000000, 32'h0000A1F1},
    {8'h00, 1'b1, 32'h11111111, 32'h11111111},
    {8'h08, 1'b0, 32'h00000000, 32'h000005FF},
    {8'h08, 1'b1, 32'h00000A5A, 32'h0000005A},
    {8'h04, 1'b1, 32'h00001111, 32'h00001111},
    {8'h08, 1'b0, 32'h00000000, 32'h00000A5A},
    {8'h03, 1'b1, 32'h00000000, 32'h00000000},
    {8'h00, 1'b0, 32'h00000000, 32'h11111111}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a);
    @(negedge clk);
    addr = a;
    #1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [NPINS-1:0] eo, ee;
    repeat (3) @(negedge clk);
    check("R1 oe during reset", 32'(pin_oe), 0);
    rst_n = 1'b1;
    rd(8'h00); check("R1 cfg0 after reset", rdata, 0);
    rd(8'h04); check("R1 cfg1 after reset", rdata, 0);
    rd(8'h08); check("R1 data after reset", rdata, 0);
    check("R1 pins idle", {pin_oe, pin_out}, 0);

    // R2 R3 R7 R9 vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      addr = VEC[i][72:65]; wr_en = VEC[i][64]; wdata = VEC[i][63:32];
      @(negedge clk);
      wr_en = 1'b0;
      #1;
      check($sformatf("R2 R3 R7 R9 vector %0d", i), rdata, VEC[i][31:0]);
    end

    check("R5 all outputs enabled", 32'(pin_oe), 32'hFFF);
    check("R5 outputs follow data", 32'(pin_out), 32'hA5A);

    wr(8'h00, 0); wr(8'h04, 0);
    check("R4 inputs undriven", {pin_oe, pin_out}, 0);
    wr(8'h08, 32'h3C3);
    check("R10 data write while input", {pin_oe, pin_out}, 0);
    wr(8'h00, 32'h11111111); wr(8'h04, 32'h1111);
    check("R10 stored data driven", 32'(pin_out), 32'h3C3);

    wr(8'h04, 0);
    wr(8'h00, 32'h000F5432);
    eo = '0; ee = '0;
    for (int n = 0; n < 3; n++) begin
      eo[n] = alt_out[n*NPINS + n];
      ee[n] = alt_oe[n*NPINS + n];
    end
    check("R6 alternate out", 32'(pin_out[7:0]), 32'(eo[7:0]));
    check("R6 alternate oe", 32'(pin_oe[7:0]), 32'(ee[7:0]));

    wr(8'h00, 0);
    @(negedge clk);
    addr = 8'h08; pin_in = 12'hABC;
    @(negedge clk); #1;
    check("R8 not after one edge", rdata, 0);
    @(negedge clk); #1;
    check("R8 after two edges", rdata, 32'hABC);

    pin_in = 12'hFFF;
    wr(8'h08, 0);
    wr(8'h00, 32'h00020001);
    rd(8'h08);
    check("R7 mixed readback", rdata, 32'hFFE);

    wr(8'h00, 1);
    pin_in = '0;
    repeat (3) @(negedge clk);
    wr(8'h04, 32'hFF);
    rd(8'h04);
    check("R11 compact data at 0x04", rdata_c, 32'h01);
    rd(8'h08);
    check("R11 compact 0x08 unmapped", rdata_c, 0);
    wr(8'h08, 0);
    rd(8'h04);
    check("R11 compact write 0x08 ignored", rdata_c, 32'h01);
    check("R11 compact pin drive", {24'h0, pin_oe_c}, 32'h01);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule